// File: doc/BRIEF.md
# Multimode Reference-Limited Decimal Counter

This block is a counting engine that takes a switch-set 10-bit reference and a 3-bit mode code and produces a 10-bit value for a decimal display. It moves at most one step per one-second tick. The tick arrives as a single-cycle enable in the system clock domain. The reference is limited to the range 0 to 999. Four behaviours are available: pass-through of the reference, count-up that lingers at the reference before starting over, count-up that keeps a tally of completed runs, and count-down that parks at zero.

The button and switch inputs are asynchronous. They enter through a two-flop synchronizer. The tick and the general reset are already in the clock domain and are used as they arrive. The display value comes from registered state, passed through one level of output selection. Any clock division, binary-to-BCD conversion and segment driving take place outside this block.

Top module: `refcount_multimode`

## Requirements
- R1: While `rst` is high at a clock edge, every register clears, and `disp_val` reads 0 after that edge.
- R2: `ref_in`, `mode_in`, `clr_btn` and `show_btn` each pass through two flip-flops. A change becomes visible at the output after the second clock edge, and not after the first.
- R3: Mode code 3'b000 shows the clamped reference on `disp_val`, and ticks do not change it.
- R4: A reference above 999 is treated as 999 in every mode.
- R5: Mode code 3'b001 starts at 0 and adds one on each tick until the count equals the reference.
- R6: In mode 3'b001, once the count equals the reference it stays there for three tick periods. The third tick after arrival returns it to 0, and counting starts again.
- R7: In mode 3'b010, a tick that finds the count at or above the reference sets the count to 0 and adds one to a repetition tally.
- R8: In mode 3'b010, while `show_btn` is held (after synchronization), `disp_val` shows the tally in place of the count.
- R9: The repetition tally stops at 999 and does not wrap.
- R10: Mode code 3'b100 loads the reference, takes one off on each tick, and stays at 0 once it gets there.
- R11: When no tick, no clear and no mode change occurs, the count and the tally hold their values.
- R12: `clr_btn` sets the count back to the start value of the current mode (the reference for 3'b100, otherwise 0) and clears the tally.
- R13: A change of the mode code restarts the new mode from its start value and clears the hold timer and the tally. The codes 3'b011, 3'b101, 3'b110 and 3'b111 show 0, and ticks have no effect in them.
- R14: With a reference of 0, the count-up modes treat 0 as reached. In mode 3'b010 the first tick therefore adds one to the tally, and the count stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | General reset, synchronous, active high |
| tick | input | 1 | One-cycle step enable, once per second |
| clr_btn | input | 1 | Counter-clear button, asynchronous |
| show_btn | input | 1 | Show-tally button, asynchronous |
| ref_in | input | 10 | Reference value from switches, asynchronous |
| mode_in | input | 3 | Mode code from switches, asynchronous |
| disp_val | output | 10 | Value for the display |

## Verification
The hardest case to reach from the ports is the tally saturating at 999, because each increment needs a complete run up to the reference. The stimulus sets the reference to 0 in mode 3'b010. Every tick then completes a run, and about eleven hundred back-to-back ticks push the tally past its limit. Holding `show_btn` makes the tally visible. The three-tick hold in mode 3'b001 is also exposed only as a count that stays still for a while. The bench samples the output after each tick to find the exact tick on which the count falls back to 0.

// File: rtl/mcnt_pkg.sv
package mcnt_pkg;

    localparam int VAL_W  = 10;
    localparam int MODE_W = 3;

    typedef logic [VAL_W-1:0]  val_t;
    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t MD_PASS   = 3'b000;
    localparam mode_t MD_HOLDUP = 3'b001;
    localparam mode_t MD_REPS   = 3'b010;
    localparam mode_t MD_DOWN   = 3'b100;

    // asynchronous controls, bundled for one synchronizer
    typedef struct packed {
        logic  clr;
        logic  show;
        mode_t mode;
        val_t  refv;
    } ctl_t;

    function automatic val_t clamp_ref(input val_t v, input val_t lim);
        return (v > lim) ? lim : v;
    endfunction

    function automatic val_t mode_start(input mode_t m, input val_t refv);
        return (m == MD_DOWN) ? refv : '0;
    endfunction

endpackage

// File: rtl/mcnt_sync.sv
module mcnt_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mcnt_engine.sv
module mcnt_engine
    import mcnt_pkg::*;
#(
    parameter int HOLD_TICKS = 3,
    parameter int REP_MAX    = 999
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  clr,
    input  mode_t mode,
    input  val_t  refv,
    output val_t  cnt,
    output val_t  reps
);
    localparam int   HW      = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam val_t REP_LIM = val_t'(REP_MAX);

    val_t          cnt_q, reps_q;
    logic [HW-1:0] hold_q;
    mode_t         last_q;
    logic          chg, reached;

    assign chg     = (mode != last_q);
    assign reached = (cnt_q >= refv);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            reps_q <= '0;
            hold_q <= '0;
            last_q <= MD_PASS;
        end else begin
            last_q <= mode;
            if (chg || clr) begin
                cnt_q  <= mode_start(mode, refv);
                reps_q <= '0;
                hold_q <= '0;
            end else if (tick) begin
                case (mode)
                    MD_HOLDUP: begin
                        if (!reached) begin
                            cnt_q <= cnt_q + 1'b1;
                        end else if (hold_q == HW'(HOLD_TICKS - 1)) begin
                            cnt_q  <= '0;
                            hold_q <= '0;
                        end else begin
                            hold_q <= hold_q + 1'b1;
                        end
                    end
                    MD_REPS: begin
                        if (reached) begin
                            cnt_q <= '0;
                            if (reps_q < REP_LIM) reps_q <= reps_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    MD_DOWN: begin
                        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                    end
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    assign cnt  = cnt_q;
    assign reps = reps_q;

    // R11
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr && !chg) |=> ($stable(cnt_q) && $stable(reps_q)));

    // R10
    down_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && !chg && mode == MD_DOWN && cnt_q != '0)
        |=> (cnt_q == val_t'($past(cnt_q) - 1'b1)));

    // R10
    down_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && !chg && mode == MD_DOWN && cnt_q == '0) |=> (cnt_q == '0));

    // R9
    reps_cap_chk: assert property (@(posedge clk) disable iff (rst)
        reps_q <= REP_LIM);

    // R6
    hold_range_chk: assert property (@(posedge clk) disable iff (rst)
        hold_q < HW'(HOLD_TICKS));

    // R13
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        chg |=> (reps_q == '0 && hold_q == '0));
endmodule

// File: rtl/mcnt_view.sv
module mcnt_view
    import mcnt_pkg::*;
(
    input  mode_t mode,
    input  logic  show,
    input  val_t  refv,
    input  val_t  cnt,
    input  val_t  reps,
    output val_t  disp
);
    always_comb begin
        case (mode)
            MD_PASS:   disp = refv;
            MD_HOLDUP: disp = cnt;
            MD_DOWN:   disp = cnt;
            MD_REPS:   disp = show ? reps : cnt;
            default:   disp = '0;
        endcase
    end
endmodule

// File: rtl/refcount_multimode.sv
module refcount_multimode
    import mcnt_pkg::*;
#(
    parameter int REF_MAX     = 999,
    parameter int HOLD_TICKS  = 3,
    parameter int REP_MAX     = 999,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr_btn,
    input  logic             show_btn,
    input  logic [VAL_W-1:0] ref_in,
    input  logic [2:0]       mode_in,
    output logic [VAL_W-1:0] disp_val
);
    localparam int   CTL_W   = $bits(ctl_t);
    localparam val_t REF_LIM = val_t'(REF_MAX);

    ctl_t ctl_raw, ctl_s;
    val_t refv, cnt, reps;

    assign ctl_raw = '{clr: clr_btn, show: show_btn, mode: mode_in, refv: ref_in};

    mcnt_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_s)
    );

    assign refv = clamp_ref(ctl_s.refv, REF_LIM);

    mcnt_engine #(.HOLD_TICKS(HOLD_TICKS), .REP_MAX(REP_MAX)) i_engine (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .clr  (ctl_s.clr),
        .mode (ctl_s.mode),
        .refv (refv),
        .cnt  (cnt),
        .reps (reps)
    );

    mcnt_view i_view (
        .mode (ctl_s.mode),
        .show (ctl_s.show),
        .refv (refv),
        .cnt  (cnt),
        .reps (reps),
        .disp (disp_val)
    );

    // R4
    ref_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_s.mode == MD_PASS) |-> (disp_val <= REF_LIM));
endmodule

// File: tb/test_refcount_multimode.sv
module test_refcount_multimode;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       clr_btn = 1'b0;
    logic       show_btn = 1'b0;
    logic [9:0] ref_in = '0;
    logic [2:0] mode_in = '0;
    logic [9:0] disp_val;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    refcount_multimode i_refcount_multimode (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .clr_btn  (clr_btn),
        .show_btn (show_btn),
        .ref_in   (ref_in),
        .mode_in  (mode_in),
        .disp_val (disp_val)
    );

    always #2 clk = ~clk;

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [9:0] exp);
        n_chk++;
        if (disp_val !== exp) begin
            n_bad++;
            $display("FAIL %s: disp_val=%0d expected=%0d", req, disp_val, exp);
        end
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            cyc(1);
            tick = 1'b0;
            cyc(1);
        end
    endtask

    task automatic set_mode(input logic [2:0] m);
        mode_in = m;
        cyc(4);
    endtask

    task automatic press_clr();
        clr_btn = 1'b1;
        cyc(3);
        clr_btn = 1'b0;
        cyc(3);
    endtask

    task automatic t_reset();
        ref_in  = 10'd5;
        mode_in = 3'b001;
        cyc(3);
        check("R1 during reset", 10'd0);
        ref_in  = 10'd0;
        mode_in = 3'b000;
        rst = 1'b0;
        cyc(4);
        check("R1 after release", 10'd0);
    endtask

    task automatic t_sync_pass();
        ref_in = 10'd123;
        cyc(4);
        check("R3 pass shows reference", 10'd123);
        ref_in = 10'd456;
        cyc(1);
        check("R2 one edge, old value", 10'd123);
        cyc(1);
        check("R2 two edges, new value", 10'd456);
        pulse_tick(3);
        check("R3 ticks ignored in pass", 10'd456);
    endtask

    task automatic t_clamp();
        ref_in = 10'd1000;
        cyc(4);
        check("R4 clamp 1000", 10'd999);
        ref_in = 10'd1023;
        cyc(4);
        check("R4 clamp 1023", 10'd999);
    endtask

    task automatic t_holdup();
        ref_in = 10'd2;
        cyc(4);
        set_mode(3'b001);
        check("R13 holdup start", 10'd0);
        pulse_tick(1);
        check("R5 step 1", 10'd1);
        pulse_tick(1);
        check("R5 reach reference", 10'd2);
        pulse_tick(1);
        check("R6 hold tick 1", 10'd2);
        pulse_tick(1);
        check("R6 hold tick 2", 10'd2);
        pulse_tick(1);
        check("R6 restart after hold", 10'd0);
        pulse_tick(1);
        check("R6 counts again", 10'd1);
        cyc(20);
        check("R11 no tick no change", 10'd1);
    endtask

    task automatic t_reps();
        set_mode(3'b010);
        check("R13 reps start", 10'd0);
        pulse_tick(2);
        check("R7 at reference", 10'd2);
        pulse_tick(1);
        check("R7 restart", 10'd0);
        show_btn = 1'b1;
        cyc(1);
        check("R2 show not yet visible", 10'd0);
        cyc(2);
        check("R8 tally shown", 10'd1);
        show_btn = 1'b0;
        cyc(3);
        pulse_tick(3);
        show_btn = 1'b1;
        cyc(3);
        check("R8 tally two", 10'd2);
        show_btn = 1'b0;
        cyc(3);
        pulse_tick(1);
        check("R7 running count", 10'd1);
        press_clr();
        check("R12 count cleared", 10'd0);
        show_btn = 1'b1;
        cyc(3);
        check("R12 tally cleared", 10'd0);
        show_btn = 1'b0;
        cyc(3);
    endtask

    task automatic t_down();
        ref_in = 10'd3;
        cyc(4);
        set_mode(3'b100);
        check("R10 load reference", 10'd3);
        pulse_tick(1);
        check("R10 step 2", 10'd2);
        pulse_tick(2);
        check("R10 reach 0", 10'd0);
        pulse_tick(3);
        check("R10 stays at 0", 10'd0);
        press_clr();
        check("R12 clear reloads reference", 10'd3);
    endtask

    task automatic t_unlisted();
        logic [2:0] codes [4] = '{3'b011, 3'b101, 3'b110, 3'b111};
        for (int k = 0; k < 4; k++) begin
            set_mode(codes[k]);
            pulse_tick(2);
            check("R13 unlisted code shows 0", 10'd0);
        end
    endtask

    task automatic t_zero_and_cap();
        ref_in = 10'd0;
        cyc(4);
        set_mode(3'b010);
        pulse_tick(1);
        check("R14 count stays 0", 10'd0);
        show_btn = 1'b1;
        cyc(3);
        check("R14 tally on first tick", 10'd1);
        pulse_tick(1100);
        check("R9 tally saturates", 10'd999);
        show_btn = 1'b0;
        cyc(3);
        set_mode(3'b001);
        set_mode(3'b010);
        show_btn = 1'b1;
        cyc(3);
        check("R13 mode change clears tally", 10'd0);
        show_btn = 1'b0;
        cyc(3);
    endtask

    initial begin
        cyc(2);
        t_reset();
        t_sync_pass();
        t_clamp();
        t_holdup();
        t_reps();
        t_down();
        t_unlisted();
        t_zero_and_cap();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #600000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule